// File: doc/BRIEF.md
# Descriptor Ring Sequencer

This block is the hardware half of a pair of buffer-descriptor rings, one for receive and one for transmit, kept in a small local store. Each descriptor holds an ownership bit, a wrap bit, a last-in-frame bit, an auxiliary bit (error on receive, append-CRC on transmit), a 16-bit length and a 32-bit buffer pointer. Software fills descriptors through a host write port, reads them back through a host read port, and starts each engine with a one-cycle kick.

The receive engine takes a counted byte stream in (one beat per byte, the last beat marked). Each frame goes into the current empty descriptor. The engine then writes back the length, including the four check-sequence bytes, and hands the descriptor back to software. The transmit engine finds a ready descriptor and plays its length out as a counted beat stream. When the last beat is accepted it returns the descriptor to software. Both engines advance one index per frame. They return to index 0 after a descriptor with the wrap bit set.

Both streams are valid/ready. A beat moves only in a cycle where valid and ready are both high. The receive side holds `rx_ready` low while it owns no descriptor. The transmit side, once it raises `tx_valid`, keeps `tx_valid`, `tx_last`, `tx_len` and `tx_crc` unchanged until the beat is taken. A host write and a hardware write-back to the same entry in the same cycle resolve in favour of the hardware.

Top module: `bd_ring_seq`

## Requirements
- R1: While `rst_n` is low or `ring_en` is low, both ring indices are 0, both tasks are stopped, `rx_ready` and `tx_valid` are low, and kicks have no effect.
- R2: `rx_ready` is high only while the receive task runs and the descriptor at `rx_index` has its ownership bit (bit 51) set. A running task that meets a descriptor with bit 51 clear stops (`rx_active` low) and resumes only on `rx_kick`.
- R3: On the accepted last receive beat, the current descriptor is rewritten with bit 51 = 0, bit 49 (last) = 1 and bits 47:32 = the number of beats in the frame, check bytes included. The wrap bit 50 and pointer bits 31:0 are unchanged.
- R4: The written-back bit 48 (error) is 1 when the frame length exceeds MAX_FRAME (1518) or `rx_bad` is high with the last beat, and 0 otherwise.
- R5: One cycle after each write-back, `rx_done` pulses. `rx_good` pulses with it when the error bit is 0 and the length minus 4 exceeds 14.
- R6: After each completed descriptor, an engine's index goes to 0 if that descriptor's wrap bit 50 was set or it was the last entry; otherwise it goes up by 1.
- R7: One cycle after the running transmit task sees a ready descriptor (bit 51 set) with a nonzero length, it presents exactly that many beats. `tx_last` is high on the final beat, and `tx_len`/`tx_crc` carry the length and bit 48 for the whole frame.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_last`, `tx_len` and `tx_crc` do not change.
- R9: After the final transmit beat is accepted, or at once for a zero-length ready descriptor (which sends no beats), bit 51 of that descriptor is cleared and all its other bits are kept.
- R10: The transmit task stops on a descriptor with bit 51 clear. It sends nothing from that index, even after software sets the bit, until `tx_kick`.
- R11: A host write (ring 0 = receive, 1 = transmit) is visible on `host_rdata` from the next cycle. The read port is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_en | input | 1 | Engine enable; low holds both engines idle at index 0 |
| rx_kick | input | 1 | Start or restart the receive task |
| tx_kick | input | 1 | Start or restart the transmit task |
| host_we | input | 1 | Host descriptor write strobe |
| host_ring | input | 1 | Ring selected for the write (0 rx, 1 tx) |
| host_idx | input | IDX_W (3) | Entry written |
| host_wdata | input | 52 | Descriptor written |
| host_rd_ring | input | 1 | Ring selected for the read |
| host_rd_idx | input | IDX_W (3) | Entry read |
| host_rdata | output | 52 | Descriptor read |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Receive beat accepted when high with valid |
| rx_last | input | 1 | Beat is the final byte of the frame |
| rx_bad | input | 1 | Frame errored; sampled with the last beat |
| rx_done | output | 1 | Pulse: receive descriptor completed |
| rx_good | output | 1 | Pulse: completed frame is usable |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Sink accepts the beat |
| tx_last | output | 1 | Final beat of the frame |
| tx_len | output | 16 | Length of the frame being sent |
| tx_crc | output | 1 | Append-CRC request for the frame being sent |
| rx_active | output | 1 | Receive task running |
| tx_active | output | 1 | Transmit task running |
| rx_index | output | IDX_W (3) | Current receive descriptor |
| tx_index | output | IDX_W (3) | Current transmit descriptor |

## Verification
A wrong ring index shows up in the cycle after the faulty write-back. `rx_index`/`tx_index` diverge at once, and the next write-back lands on the wrong entry, which the host read port exposes. A stale ownership bit shows as `rx_ready` or `tx_valid` rising or staying low in the wrong cycle. A wrong beat counter shows as `tx_last` on the wrong beat or as a written-back length that is off by the error. Because the reference model is compared every clock, each of these is caught within one cycle of the first visible difference.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;
  localparam int LEN_W = 16;
  localparam int PTR_W = 32;

  // own: rx = empty (hardware owns), tx = ready to send
  // aux: rx = error,                 tx = append CRC
  typedef struct packed {
    logic             own;
    logic             wrap;
    logic             last;
    logic             aux;
    logic [LEN_W-1:0] len;
    logic [PTR_W-1:0] ptr;
  } bd_t;

  localparam int BD_W = $bits(bd_t);
  localparam int N_RINGS = 2;
endpackage

// File: rtl/bd_bank.sv
module bd_bank
  import bd_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  bd_t              host_wd,
  input  logic             hw_we,
  input  logic [IDX_W-1:0] hw_idx,
  input  bd_t              hw_wd,
  input  logic [IDX_W-1:0] rd_a_idx,
  output bd_t              rd_a,
  input  logic [IDX_W-1:0] rd_b_idx,
  output bd_t              rd_b
);
  bd_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        // hardware write-back wins over a host write to the same entry
        if (hw_we && hw_idx == IDX_W'(i))
          mem[i] <= hw_wd;
        else if (host_we && host_idx == IDX_W'(i))
          mem[i] <= host_wd;
      end
    end
  end

  assign rd_a = mem[rd_a_idx];
  assign rd_b = mem[rd_b_idx];
endmodule

// File: rtl/bd_rx_engine.sv
module bd_rx_engine
  import bd_ring_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int MAX_FRAME = 1518,
  parameter int MIN_GOOD  = 18,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             kick,
  input  bd_t              cur,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             in_bad,
  output logic             in_ready,
  output logic [IDX_W-1:0] idx,
  output logic             wb_we,
  output bd_t              wb_bd,
  output logic             done,
  output logic             good,
  output logic             active
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [LEN_W-1:0] LEN_SAT  = '1;
  localparam logic [LEN_W-1:0] MAX_L    = LEN_W'(MAX_FRAME);
  localparam logic [LEN_W-1:0] GOOD_L   = LEN_W'(MIN_GOOD);

  logic             run;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] frame_len;
  logic             hs;
  logic             err;
  logic [IDX_W-1:0] next_idx;

  assign in_ready  = en && run && cur.own;
  assign hs        = in_valid && in_ready;
  assign frame_len = (cnt == LEN_SAT) ? cnt : cnt + 1'b1;
  assign err       = (frame_len > MAX_L) || in_bad;
  assign wb_we     = hs && in_last;
  assign next_idx  = (cur.wrap || idx == LAST_IDX) ? '0 : idx + 1'b1;
  assign active    = run;

  always_comb begin
    wb_bd      = cur;
    wb_bd.own  = 1'b0;
    wb_bd.last = 1'b1;
    wb_bd.aux  = err;
    wb_bd.len  = frame_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; cnt <= '0; idx <= '0; done <= 1'b0; good <= 1'b0;
    end else if (!en) begin
      run <= 1'b0; cnt <= '0; idx <= '0; done <= 1'b0; good <= 1'b0;
    end else begin
      if (kick)
        run <= 1'b1;
      else if (run && !cur.own)
        run <= 1'b0;
      if (hs)
        cnt <= in_last ? '0 : frame_len;
      if (wb_we)
        idx <= next_idx;
      done <= wb_we;
      good <= wb_we && !err && (frame_len > GOOD_L);
    end
  end

  a_r6_rx_step: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (wb_we && !cur.wrap && idx != LAST_IDX) |=> (idx == $past(idx) + 1'b1))
    else $error("rx index did not step");

  a_r6_rx_wrap: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (wb_we && cur.wrap) |=> (idx == '0))
    else $error("rx index did not wrap");

  a_r1_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!in_ready && idx == '0 && !active))
    else $error("rx engine active while disabled");

  a_r2_rx_stalls: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (!active && !kick) |=> !in_ready)
    else $error("rx accepted data while stopped");
endmodule

// File: rtl/bd_tx_engine.sv
module bd_tx_engine
  import bd_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             kick,
  input  bd_t              cur,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_last,
  output logic [LEN_W-1:0] out_len,
  output logic             out_crc,
  output logic [IDX_W-1:0] idx,
  output logic             wb_we,
  output bd_t              wb_bd,
  output logic             active
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic             run;
  logic             busy;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] hold_len;
  logic             hold_crc;
  logic             start;
  logic             zero;
  logic             hs;
  logic [IDX_W-1:0] next_idx;

  assign start    = en && run && !busy && cur.own;
  assign zero     = start && (cur.len == '0);
  assign hs       = busy && out_ready;
  assign wb_we    = (hs && cnt == LEN_W'(1)) || zero;
  assign next_idx = (cur.wrap || idx == LAST_IDX) ? '0 : idx + 1'b1;

  assign out_valid = busy;
  assign out_last  = busy && (cnt == LEN_W'(1));
  assign out_len   = busy ? hold_len : '0;
  assign out_crc   = busy && hold_crc;
  assign active    = run;

  always_comb begin
    wb_bd     = cur;
    wb_bd.own = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; busy <= 1'b0; cnt <= '0; idx <= '0;
      hold_len <= '0; hold_crc <= 1'b0;
    end else if (!en) begin
      run <= 1'b0; busy <= 1'b0; cnt <= '0; idx <= '0;
      hold_len <= '0; hold_crc <= 1'b0;
    end else begin
      if (kick)
        run <= 1'b1;
      else if (run && !busy && !cur.own)
        run <= 1'b0;
      if (start && !zero) begin
        busy     <= 1'b1;
        cnt      <= cur.len;
        hold_len <= cur.len;
        hold_crc <= cur.aux;
      end
      if (hs) begin
        cnt <= cnt - 1'b1;
        if (cnt == LEN_W'(1)) busy <= 1'b0;
      end
      if (wb_we)
        idx <= next_idx;
    end
  end

  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_len) && $stable(out_last) && $stable(out_crc)))
    else $error("tx beat changed under back-pressure");

  a_r9_tx_step: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (wb_we && !cur.wrap && idx != LAST_IDX) |=> (idx == $past(idx) + 1'b1))
    else $error("tx index did not step");

  a_r6_tx_wrap: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (wb_we && cur.wrap) |=> (idx == '0))
    else $error("tx index did not wrap");

  a_r10_tx_no_start: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (!active && !out_valid && !kick) |=> !out_valid)
    else $error("tx sent while stopped");

  a_r1_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!out_valid && idx == '0 && !active))
    else $error("tx engine active while disabled");
endmodule

// File: rtl/bd_ring_seq.sv
module bd_ring_seq
  import bd_ring_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int MAX_FRAME = 1518,
  parameter int FCS_LEN   = 4,
  parameter int HDR_LEN   = 14,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_en,
  input  logic             rx_kick,
  input  logic             tx_kick,
  input  logic             host_we,
  input  logic             host_ring,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [BD_W-1:0]  host_wdata,
  input  logic             host_rd_ring,
  input  logic [IDX_W-1:0] host_rd_idx,
  output logic [BD_W-1:0]  host_rdata,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic             rx_last,
  input  logic             rx_bad,
  output logic             rx_done,
  output logic             rx_good,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             tx_last,
  output logic [LEN_W-1:0] tx_len,
  output logic             tx_crc,
  output logic             rx_active,
  output logic             tx_active,
  output logic [IDX_W-1:0] rx_index,
  output logic [IDX_W-1:0] tx_index
);
  localparam int MIN_GOOD = FCS_LEN + HDR_LEN;

  logic             hw_we  [N_RINGS];
  logic [IDX_W-1:0] hw_idx [N_RINGS];
  bd_t              hw_wd  [N_RINGS];
  bd_t              cur    [N_RINGS];
  bd_t              hrd    [N_RINGS];

  assign hw_idx[0] = rx_index;
  assign hw_idx[1] = tx_index;

  for (genvar g = 0; g < N_RINGS; g++) begin : g_ring
    bd_bank #(.DEPTH(DEPTH)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_we  (host_we && (host_ring == 1'(g))),
      .host_idx (host_idx),
      .host_wd  (host_wdata),
      .hw_we    (hw_we[g]),
      .hw_idx   (hw_idx[g]),
      .hw_wd    (hw_wd[g]),
      .rd_a_idx (host_rd_idx),
      .rd_a     (hrd[g]),
      .rd_b_idx (hw_idx[g]),
      .rd_b     (cur[g])
    );
  end

  assign host_rdata = host_rd_ring ? hrd[1] : hrd[0];

  bd_rx_engine #(.DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME), .MIN_GOOD(MIN_GOOD)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ring_en),
    .kick     (rx_kick),
    .cur      (cur[0]),
    .in_valid (rx_valid),
    .in_last  (rx_last),
    .in_bad   (rx_bad),
    .in_ready (rx_ready),
    .idx      (rx_index),
    .wb_we    (hw_we[0]),
    .wb_bd    (hw_wd[0]),
    .done     (rx_done),
    .good     (rx_good),
    .active   (rx_active)
  );

  bd_tx_engine #(.DEPTH(DEPTH)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ring_en),
    .kick      (tx_kick),
    .cur       (cur[1]),
    .out_valid (tx_valid),
    .out_ready (tx_ready),
    .out_last  (tx_last),
    .out_len   (tx_len),
    .out_crc   (tx_crc),
    .idx       (tx_index),
    .wb_we     (hw_we[1]),
    .wb_bd     (hw_wd[1]),
    .active    (tx_active)
  );

  a_r3_rx_wb_hands_back: assert property (@(posedge clk) disable iff (!rst_n)
    hw_we[0] |-> (!hw_wd[0].own && hw_wd[0].last && hw_wd[0].len != '0))
    else $error("rx write-back malformed");
endmodule

// File: tb/test_bd_ring_seq.sv
module test_bd_ring_seq;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ring_en = 1'b0;
  logic        rx_kick = 1'b0, tx_kick = 1'b0;
  logic        host_we = 1'b0, host_ring = 1'b0;
  logic [2:0]  host_idx = '0;
  logic [51:0] host_wdata = '0;
  logic        host_rd_ring = 1'b0;
  logic [2:0]  host_rd_idx = '0;
  logic [51:0] host_rdata;
  logic        rx_valid = 1'b0, rx_ready, rx_last = 1'b0, rx_bad = 1'b0;
  logic        rx_done, rx_good;
  logic        tx_valid, tx_ready = 1'b1, tx_last, tx_crc;
  logic [15:0] tx_len;
  logic        rx_active, tx_active;
  logic [2:0]  rx_index, tx_index;

  bd_ring_seq i_bd_ring_seq (
    .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .rx_kick(rx_kick), .tx_kick(tx_kick),
    .host_we(host_we), .host_ring(host_ring), .host_idx(host_idx), .host_wdata(host_wdata),
    .host_rd_ring(host_rd_ring), .host_rd_idx(host_rd_idx), .host_rdata(host_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_last(rx_last), .rx_bad(rx_bad),
    .rx_done(rx_done), .rx_good(rx_good), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last), .tx_len(tx_len), .tx_crc(tx_crc), .rx_active(rx_active),
    .tx_active(tx_active), .rx_index(rx_index), .tx_index(tx_index)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0, rd_manual = 0, bp_mode = 0;
  int n_beats = 0, n_lasts = 0, n_done = 0, n_good = 0;

  function automatic logic [51:0] mk(bit own, bit wrap, bit last, bit aux, int len, logic [31:0] ptr);
    return {own, wrap, last, aux, 16'(len), ptr};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [51:0] m_rx [D];
  logic [51:0] m_tx [D];
  int  m_rxi = 0, m_txi = 0, m_cnt = 0, m_rxcnt = 0, m_hlen = 0;
  bit  m_rxrun = 0, m_txrun = 0, m_busy = 0, m_hcrc = 0, m_done = 0, m_good = 0;

  initial for (int i = 0; i < D; i++) begin m_rx[i] = '0; m_tx[i] = '0; end

  always @(negedge clk) begin
    bit e_rdy, hs, rx_wb, tx_wb, nb, nrun, ntrun, t_own, ndone, ngood;
    int flen, t_len, nrxi, ntxi, ncnt, nrxcnt;
    logic [51:0] rx_val, tx_val;
    #5;
    cyc++;
    e_rdy = ring_en && m_rxrun && m_rx[m_rxi][51];
    check("R2 rx_ready", rx_ready, e_rdy);
    check("R5 rx_done", rx_done, m_done);
    check("R5 rx_good", rx_good, m_good);
    check("R7 tx_valid", tx_valid, m_busy);
    check("R7 tx_last", tx_last, m_busy && m_cnt == 1);
    check("R8 tx_len", tx_len, m_busy ? m_hlen : 0);
    check("R8 tx_crc", tx_crc, m_busy && m_hcrc);
    check("R6 rx_index", rx_index, m_rxi);
    check("R6 tx_index", tx_index, m_txi);
    check("R2 rx_active", rx_active, m_rxrun);
    check("R10 tx_active", tx_active, m_txrun);
    check("R3 host_rdata", host_rdata, host_rd_ring ? m_tx[host_rd_idx] : m_rx[host_rd_idx]);
    if (tx_valid && tx_ready) begin n_beats++; if (tx_last) n_lasts++; end
    if (rx_done) n_done++;
    if (rx_good) n_good++;

    if (!rst_n) begin
      for (int i = 0; i < D; i++) begin m_rx[i] = '0; m_tx[i] = '0; end
      m_rxi = 0; m_txi = 0; m_cnt = 0; m_rxcnt = 0; m_hlen = 0;
      m_rxrun = 0; m_txrun = 0; m_busy = 0; m_hcrc = 0; m_done = 0; m_good = 0;
    end else begin
      rx_wb = 0; tx_wb = 0; ndone = 0; ngood = 0;
      nrxi = m_rxi; ntxi = m_txi; ncnt = m_cnt; nrxcnt = m_rxcnt;
      nb = m_busy; nrun = m_rxrun; ntrun = m_txrun;
      rx_val = m_rx[m_rxi]; tx_val = m_tx[m_txi];
      if (ring_en) begin
        hs = rx_valid && e_rdy;
        if (hs) begin
          flen = (m_rxcnt == 65535) ? 65535 : m_rxcnt + 1;
          if (rx_last) begin
            bit err;
            err = (flen > 1518) || rx_bad;
            rx_val = mk(0, m_rx[m_rxi][50], 1, err, flen, m_rx[m_rxi][31:0]);
            rx_wb = 1; ndone = 1; ngood = !err && (flen - 4 > 14);
            nrxi = (m_rx[m_rxi][50] || m_rxi == D-1) ? 0 : m_rxi + 1;
            nrxcnt = 0;
          end else nrxcnt = flen;
        end
        if (rx_kick) nrun = 1; else if (m_rxrun && !m_rx[m_rxi][51]) nrun = 0;
        t_own = m_tx[m_txi][51]; t_len = int'(m_tx[m_txi][47:32]);
        if (m_busy && tx_ready) begin
          if (m_cnt == 1) begin nb = 0; tx_wb = 1; end
          ncnt = m_cnt - 1;
        end else if (!m_busy && m_txrun && t_own) begin
          if (t_len == 0) tx_wb = 1;
          else begin nb = 1; ncnt = t_len; m_hlen = t_len; m_hcrc = m_tx[m_txi][48]; end
        end
        if (tx_kick) ntrun = 1; else if (m_txrun && !m_busy && !t_own) ntrun = 0;
        if (tx_wb) begin
          tx_val[51] = 1'b0;
          ntxi = (m_tx[m_txi][50] || m_txi == D-1) ? 0 : m_txi + 1;
        end
      end else begin
        nrxi = 0; ntxi = 0; ncnt = 0; nrxcnt = 0; nb = 0; nrun = 0; ntrun = 0;
        m_hlen = 0; m_hcrc = 0;
      end
      if (host_we) begin
        if (host_ring) m_tx[host_idx] = host_wdata; else m_rx[host_idx] = host_wdata;
      end
      if (rx_wb) m_rx[m_rxi] = rx_val;
      if (tx_wb) m_tx[m_txi] = tx_val;
      m_rxi = nrxi; m_txi = ntxi; m_cnt = ncnt; m_rxcnt = nrxcnt;
      m_busy = nb; m_rxrun = nrun; m_txrun = ntrun; m_done = ndone; m_good = ngood;
    end
  end

  // read-port sweep and sink back-pressure
  always @(negedge clk) begin
    #1;
    if (!rd_manual) begin
      host_rd_idx = 3'(cyc);
      host_rd_ring = cyc[3];
    end
    tx_ready = bp_mode ? (cyc % 3 != 0) : 1'b1;
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr_bd(bit ring, int idx, logic [51:0] v);
    @(negedge clk); host_we = 1; host_ring = ring; host_idx = 3'(idx); host_wdata = v;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd_check(string tag, bit ring, int idx, logic [51:0] exp);
    @(negedge clk); rd_manual = 1; #2;
    host_rd_ring = ring; host_rd_idx = 3'(idx);
    #3; check(tag, host_rdata, exp);
    rd_manual = 0;
  endtask

  task automatic kick(bit tx);
    @(negedge clk); if (tx) tx_kick = 1; else rx_kick = 1;
    @(negedge clk); tx_kick = 0; rx_kick = 0;
  endtask

  task automatic rx_frame(int n, bit bad);
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      rx_valid = 1; rx_last = (i == n-1); rx_bad = bad && (i == n-1);
      #5; if (rx_ready) i++;
    end
    @(negedge clk); rx_valid = 0; rx_last = 0; rx_bad = 0;
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic summary;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=complete");
      summary();
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    idle(2);
    // R1: idle state after reset
    check("R1 rx_index", rx_index, 0);
    check("R1 tx_index", tx_index, 0);
    check("R1 rx_ready", rx_ready, 0);
    check("R1 tx_valid", tx_valid, 0);
    kick(0); idle(2);
    check("R1 kick ignored while disabled", rx_active, 0);

    // receive ring of four, wrap at 3
    for (int i = 0; i < 4; i++) wr_bd(0, i, mk(1, i == 3, 0, 0, 0, 32'h1000 + i));
    rd_check("R11 host readback", 0, 3, mk(1, 1, 0, 0, 0, 32'h1003));
    @(negedge clk); ring_en = 1;
    kick(0);
    rx_frame(20, 0);
    rx_frame(18, 0);
    rx_frame(19, 0);
    rx_frame(30, 1);
    idle(3);
    rd_check("R3 rx writeback", 0, 1, mk(0, 0, 1, 0, 18, 32'h1001));
    rd_check("R4 rx_bad sets error", 0, 3, mk(0, 1, 1, 1, 30, 32'h1003));
    check("R6 rx wrap to 0", rx_index, 0);
    check("R2 rx stopped on full ring", rx_active, 0);
    // stream offered while stopped is not taken
    @(negedge clk); rx_valid = 1; rx_last = 1;
    idle(5);
    @(negedge clk); rx_valid = 0; rx_last = 0;
    rd_check("R2 no writeback while stopped", 0, 0, mk(0, 0, 1, 0, 20, 32'h1000));

    wr_bd(0, 0, mk(1, 0, 0, 0, 0, 32'h2000));
    wr_bd(0, 1, mk(1, 0, 0, 0, 0, 32'h2001));
    kick(0);
    rx_frame(1519, 0);
    rx_frame(1518, 0);
    idle(3);
    rd_check("R4 oversize error", 0, 0, mk(0, 0, 1, 1, 1519, 32'h2000));
    rd_check("R4 max size clean", 0, 1, mk(0, 0, 1, 0, 1518, 32'h2001));
    check("R5 done count", n_done, 6);
    check("R5 good count", n_good, 3);

    // transmit ring of three, wrap at 2, with back-pressure
    wr_bd(1, 0, mk(1, 0, 0, 1, 5, 32'h3000));
    wr_bd(1, 1, mk(1, 0, 0, 0, 0, 32'h3001));
    wr_bd(1, 2, mk(1, 1, 0, 0, 3, 32'h3002));
    @(negedge clk); bp_mode = 1;
    kick(1);
    idle(40);
    check("R7 beat count", n_beats, 8);
    check("R7 last count", n_lasts, 2);
    rd_check("R9 zero-length retired", 1, 1, mk(0, 0, 0, 0, 0, 32'h3001));
    rd_check("R9 retired kept fields", 1, 2, mk(0, 1, 0, 0, 3, 32'h3002));
    check("R6 tx wrap to 0", tx_index, 0);
    check("R10 tx stopped", tx_active, 0);
    wr_bd(1, 0, mk(1, 0, 0, 0, 2, 32'h3100));
    idle(10);
    check("R10 no send without kick", n_beats, 8);
    kick(1);
    idle(12);
    check("R10 send after kick", n_beats, 10);
    rd_check("R9 tx retire", 1, 0, mk(0, 0, 0, 0, 2, 32'h3100));

    // R1: disable clears indices
    check("R1 index before disable", tx_index, 1);
    @(negedge clk); ring_en = 0;
    @(negedge clk); ring_en = 1;
    #5;
    check("R1 tx index cleared", tx_index, 0);
    check("R1 rx index cleared", rx_index, 0);
    wr_bd(1, 5, mk(1, 0, 1, 1, 77, 32'hdead_beef));
    rd_check("R11 host write tx", 1, 5, mk(1, 0, 1, 1, 77, 32'hdead_beef));
    idle(3);
    summary();
  end
endmodule